// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a chain of boundary-scan cells that sits between core logic and device pins. A test access port controller drives it with capture, shift and update strobes, a test-mode select and a serial input. The chain returns a serial output. There are two kinds of cell, and a parameter mask picks the kind of each one. An output cell sits between a core output and a pin. An input cell sits between a pin and the core.

Every cell has a serial shift stage built from a flip-flop clocked on the rising test clock. Output cells also have a level-sensitive hold latch that feeds a test multiplexer. During normal operation the system value passes straight through every cell. Shifting and capturing then let pin values be observed without disturbing the device. When test mode is selected, each output cell drives its pin from the latch. Input cells never alter the value they carry. An asynchronous active-low reset clears both stages and forces system function.

The serial interface is bit-serial under strobe control, so it has no valid/ready handshake. All pins are plain control and data pins.

Top module: `bscan_chain`

## Requirements
- R1: On a rising `tck_i` with `capture_i` high, every cell's shift flip-flop loads its own `sys_in_i` bit. Capture takes priority over shift.
- R2: On a rising `tck_i` with `shift_i` high and `capture_i` low, cell i loads the old value of cell i-1, and cell 0 loads `tdi_i`.
- R3: `tdo_o` is the shift flip-flop of cell CELLS-1. A captured word therefore appears at `tdo_o` highest cell first, one bit per shift edge.
- R4: On a rising edge with both `capture_i` and `shift_i` low, every shift flip-flop holds its value.
- R5: An output cell's latch is transparent to its shift flip-flop while `update_i` is high. While `update_i` is low, the latch holds, even across further shifting.
- R6: With `test_mode_i` low, every `sys_out_o` bit equals its `sys_in_i` bit.
- R7: With `test_mode_i` high, each output cell drives `sys_out_o` from its latch. An output cell is a cell whose `OUT_MASK` bit is 1.
- R8: An input cell is a cell whose `OUT_MASK` bit is 0. Its `sys_out_o` bit equals its `sys_in_i` bit in every mode.
- R9: While `trst_n_i` is low, both stages of every cell read 0 and `sys_out_o` equals `sys_in_i`, whatever `test_mode_i` is. After reset is released, a test-mode output cell drives 0 until it is next updated.
- R10: Capturing and shifting with `test_mode_i` low leave `sys_out_o` equal to `sys_in_i`. This is the non-intrusive sample case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock; shift stages advance on its rising edge |
| trst_n_i | input | 1 | Asynchronous active-low reset of both stages; also forces system function |
| capture_i | input | 1 | Load parallel inputs into the shift stages |
| shift_i | input | 1 | Move the chain one cell toward `tdo_o` |
| update_i | input | 1 | Level strobe; output latches are transparent while it is high |
| test_mode_i | input | 1 | 1 = output cells drive pins from their latches |
| tdi_i | input | 1 | Serial data into cell 0 |
| tdo_o | output | 1 | Serial data from cell CELLS-1 |
| sys_in_i | input | CELLS | Per-cell system value (core output or pin value) |
| sys_out_o | output | CELLS | Per-cell driven value (pin or core input) |

## Verification
A corrupt shift flip-flop appears at `tdo_o`. The delay is the number of shift edges that separate that cell from the end of the chain, at most CELLS edges. A corrupt hold latch stays hidden during normal operation. It appears on the affected `sys_out_o` bit as soon as test mode is raised, with no clock needed, because the multiplexer is combinational. A broken test multiplexer or a broken input-cell path shows on `sys_out_o` in the same cycle that `test_mode_i` or `sys_in_i` changes.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic {
    KIND_INPUT  = 1'b0,
    KIND_OUTPUT = 1'b1
  } cell_kind_e;

  function automatic cell_kind_e kind_of(input logic bit_val);
    return bit_val ? KIND_OUTPUT : KIND_INPUT;
  endfunction

endpackage

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage (
  input  logic tck_i,
  input  logic rst_n_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic par_i,
  input  logic ser_i,
  output logic ser_o
);

  logic sff_q;

  always_ff @(posedge tck_i or negedge rst_n_i) begin
    if (!rst_n_i)       sff_q <= 1'b0;
    else if (capture_i) sff_q <= par_i;
    else if (shift_i)   sff_q <= ser_i;
  end

  assign ser_o = sff_q;

  // R1
  p_capture_r1: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    capture_i |=> ser_o == $past(par_i));
  // R2
  p_shift_r2: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (shift_i && !capture_i) |=> ser_o == $past(ser_i));
  // R4
  p_hold_r4: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (!shift_i && !capture_i) |=> $stable(ser_o));

endmodule

// File: rtl/bscan_cell_in.sv
module bscan_cell_in (
  input  logic tck_i,
  input  logic rst_n_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic par_i,
  input  logic ser_i,
  output logic ser_o,
  output logic sys_o
);

  bscan_shift_stage u_stage (
    .tck_i    (tck_i),
    .rst_n_i  (rst_n_i),
    .capture_i(capture_i),
    .shift_i  (shift_i),
    .par_i    (par_i),
    .ser_i    (ser_i),
    .ser_o    (ser_o)
  );

  // observe-only cell: the pin value always reaches the core
  assign sys_o = par_i;

endmodule

// File: rtl/bscan_cell_out.sv
module bscan_cell_out (
  input  logic tck_i,
  input  logic rst_n_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic test_i,
  input  logic par_i,
  input  logic ser_i,
  output logic ser_o,
  output logic sys_o
);

  logic sff;
  logic hold_q;

  bscan_shift_stage u_stage (
    .tck_i    (tck_i),
    .rst_n_i  (rst_n_i),
    .capture_i(capture_i),
    .shift_i  (shift_i),
    .par_i    (par_i),
    .ser_i    (ser_i),
    .ser_o    (sff)
  );

  // level-sensitive hold stage, open while the update strobe is high
  always_latch begin
    if (!rst_n_i)      hold_q = 1'b0;
    else if (update_i) hold_q = sff;
  end

  assign ser_o = sff;
  assign sys_o = test_i ? hold_q : par_i;

  // R5: transparent while update is high
  p_transparent_r5: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    update_i |-> hold_q == sff);

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int unsigned          CELLS    = 8,
  parameter logic [CELLS-1:0]     OUT_MASK = 8'hF0
) (
  input  logic             tck_i,
  input  logic             trst_n_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             test_mode_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [CELLS-1:0] sys_in_i,
  output logic [CELLS-1:0] sys_out_o
);
  import bscan_pkg::*;

  localparam int unsigned LAST = CELLS - 1;

  logic [CELLS:0] link;
  logic           test_q;

  // reset forces system function regardless of the select
  assign test_q  = test_mode_i & trst_n_i;
  assign link[0] = tdi_i;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    if (kind_of(OUT_MASK[i]) == KIND_OUTPUT) begin : g_out
      bscan_cell_out u_cell (
        .tck_i    (tck_i),
        .rst_n_i  (trst_n_i),
        .capture_i(capture_i),
        .shift_i  (shift_i),
        .update_i (update_i),
        .test_i   (test_q),
        .par_i    (sys_in_i[i]),
        .ser_i    (link[i]),
        .ser_o    (link[i+1]),
        .sys_o    (sys_out_o[i])
      );
    end else begin : g_in
      bscan_cell_in u_cell (
        .tck_i    (tck_i),
        .rst_n_i  (trst_n_i),
        .capture_i(capture_i),
        .shift_i  (shift_i),
        .par_i    (sys_in_i[i]),
        .ser_i    (link[i]),
        .ser_o    (link[i+1]),
        .sys_o    (sys_out_o[i])
      );
    end
  end

  assign tdo_o = link[CELLS];

  // R3: serial output advances by one cell per shift edge
  p_tdo_r3: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (shift_i && !capture_i) |=> tdo_o == $past(link[LAST]));

  // R6: normal mode passes every system value
  p_sysfn_r6: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (!test_mode_i && $stable(sys_in_i) && $stable(test_mode_i)) |-> sys_out_o == sys_in_i);

endmodule

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb;

  localparam int unsigned N    = 8;
  localparam logic [N-1:0] MASK = 8'hF0;

  logic         tck = 1'b0;
  logic         trst_n, capture, shift, update, test_mode, tdi;
  logic         tdo;
  logic [N-1:0] sys_in, sys_out;

  int tests = 0;
  int fails = 0;

  always #5 tck = ~tck;

  bscan_chain #(.CELLS(N), .OUT_MASK(MASK)) u_dut (
    .tck_i(tck), .trst_n_i(trst_n), .capture_i(capture), .shift_i(shift),
    .update_i(update), .test_mode_i(test_mode), .tdi_i(tdi), .tdo_o(tdo),
    .sys_in_i(sys_in), .sys_out_o(sys_out)
  );

  // {capture word, load word}
  localparam logic [15:0] VEC [4] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h96_C3};

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_capture();
    @(negedge tck); capture = 1'b1;
    @(negedge tck); capture = 1'b0;
  endtask

  // pushes w[N-1] first so cell i ends holding w[i]; returns bits seen on tdo
  task automatic do_shift(input logic [N-1:0] w, output logic [N-1:0] seen);
    for (int k = 0; k < N; k++) begin
      @(negedge tck);
      shift = 1'b1;
      tdi   = w[N-1-k];
      #1 seen[N-1-k] = tdo;
    end
    @(negedge tck); shift = 1'b0;
  endtask

  task automatic do_update();
    @(negedge tck); update = 1'b1;
    #2 update = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] seen;
    trst_n = 1'b0; capture = 1'b0; shift = 1'b0; update = 1'b0;
    test_mode = 1'b1; tdi = 1'b0; sys_in = 8'h5A;
    #23;
    check("R9 reset pins follow system", sys_out, 8'h5A);
    check("R9 reset tdo low", {7'd0, tdo}, 8'h00);
    @(negedge tck); trst_n = 1'b1; #1;
    check("R9 post-reset test mode drives cleared latches", sys_out, 8'h0A);
    test_mode = 1'b0;

    // table walk: capture, shift out/in, update, test mode, normal mode
    for (int v = 0; v < 4; v++) begin
      logic [N-1:0] cap_w, ld_w;
      cap_w = VEC[v][15:8];
      ld_w  = VEC[v][7:0];
      sys_in = cap_w;
      do_capture();
      do_shift(ld_w, seen);
      check("R1 R2 R3 captured word on tdo", seen, cap_w);
      check("R10 sample/shift leaves pins", sys_out, cap_w);
      do_update();
      test_mode = 1'b1; #1;
      check("R7 R8 test-mode pins", sys_out, (ld_w & MASK) | (cap_w & ~MASK));
      test_mode = 1'b0; #1;
      check("R6 normal-mode pins", sys_out, cap_w);
    end

    // R4: idle edges hold the captured word
    sys_in = 8'hE7;
    do_capture();
    sys_in = 8'h18;
    repeat (3) @(negedge tck);
    do_shift(8'h0F, seen);
    check("R4 hold with no strobe", seen, 8'hE7);

    // R5: latches still hold the last update (C3) after fresh shifting
    test_mode = 1'b1; #1;
    check("R5 latch holds without update", sys_out, 8'hC8);
    sys_in = 8'h0A; #1;
    check("R8 input cells follow system in test mode", sys_out, 8'hCA);
    do_update(); #1;
    check("R5 latch opens on update", sys_out, 8'h0A);

    // R9: reset mid test mode returns pins to system function
    sys_in = 8'h77;
    @(negedge tck); trst_n = 1'b0; #1;
    check("R9 reset with test mode high", sys_out, 8'h77);
    @(negedge tck); trst_n = 1'b1; #1;
    check("R9 latches cleared after reset", sys_out, 8'h07);
    test_mode = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule